// File: doc/BRIEF.md
# Circular-Buffer Address Generator for Dual Data-Memory Pointers

This block produces the data-memory addresses for two independent pointer banks, called X and Y. Each bank holds two pointer registers and one index register. On every transfer the selected pointer drives the bank's address bus with its current value. At the clock edge that ends the transfer the pointer is then either left alone, stepped by two, or stepped by the bank's index register.

A shared pair of bounds (a buffer start and a buffer end) can make either bank's pointers wrap through a circular buffer. Each bank has its own enable for this. Wrap is decided before the step is applied. If the pointer that is about to be updated already sits on the end bound (upper address bits only), the pointer reloads the start bound instead of taking the stepped value. Both banks can move in the same cycle, and each compares against the shared end bound on its own.

Instruction decode supplies the transfer requests and the register writes. The memories themselves sit outside this block.

Top module: `modaddr_gen`

## Requirements
- R1: After a synchronous reset all four pointers, both index registers, both bounds and both bank enables are zero.
- R2: When `wr_en` is high, `wr_sel` picks the register that takes `wr_data` at the next edge. The codes are 0 = X pointer 0, 1 = X pointer 1, 2 = Y pointer 0, 3 = Y pointer 1, 4 = X index, 5 = Y index. Pointers and index registers take `wr_data[15:0]`. Code 6 loads the bounds word, with the end bound in bits 31:16 and the start bound in bits 15:0. Code 7 loads the enables, with bit 0 for X and bit 1 for Y.
- R3: `x_addr`/`y_addr` show the pointer chosen by `x_sel`/`y_sel` (0 = pointer 0, 1 = pointer 1) combinationally. This is the value before any update.
- R4: For a request in mode 1 the chosen pointer becomes pointer + 2 at the clock edge. In mode 2 it becomes pointer + bank index. Both results wrap modulo 2^16. The other pointer of the bank does not change. `x_next`/`y_next` show the value that will be written.
- R5: When a bank is enabled, a mode 1 or mode 2 request whose pointer bits 15:1 equal the end bound's bits 15:1 loads the start bound's bits 15:1 into the pointer and keeps the pointer's bit 0.
- R6: Mode 0 and the reserved mode 3 leave the pointer unchanged, even when it equals the end bound.
- R7: Each bank wraps only when its own enable bit is set. A disabled bank steps past the end bound.
- R8: Bit 0 of both bounds is ignored, both for the compare and for the reload.
- R9: X and Y requests in the same cycle update both banks in parallel, each against the shared bounds.
- R10: A register write to a pointer in the same cycle as that pointer's update wins over the update.
- R11: Wrap depends only on the value before the update. A step that jumps over the end bound does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_req | input | 1 | X bank transfer this cycle |
| x_mode | input | 2 | X update mode (0 hold, 1 +2, 2 +index, 3 hold) |
| x_sel | input | 1 | X pointer choice |
| y_req | input | 1 | Y bank transfer this cycle |
| y_mode | input | 2 | Y update mode |
| y_sel | input | 1 | Y pointer choice |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write target code |
| wr_data | input | 32 | Register write data |
| x_addr | output | 16 | X bus address (pre-update pointer) |
| y_addr | output | 16 | Y bus address (pre-update pointer) |
| x_next | output | 16 | X pointer value to be written back |
| y_next | output | 16 | Y pointer value to be written back |

## Verification
The bus addresses and the next-pointer values are combinational. The bench therefore checks them in the same cycle the request is driven, one time step after the inputs settle and well before the edge. Pointer write-back and register writes become visible exactly one edge later. Each such result is read back through the bus address in the cycle after the commit edge, with requests idle. Every expected item is queued by the driver just before its sample point, and the monitor pops it and compares it at that point.

// File: rtl/mag_pkg.sv
`timescale 1ns/1ps
package mag_pkg;
    localparam int NBANK = 2;

    typedef enum logic [1:0] {
        AM_HOLD = 2'd0,
        AM_INC  = 2'd1,
        AM_IDX  = 2'd2,
        AM_RSVD = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        RS_XP0 = 3'd0,
        RS_XP1 = 3'd1,
        RS_YP0 = 3'd2,
        RS_YP1 = 3'd3,
        RS_XIX = 3'd4,
        RS_YIX = 3'd5,
        RS_BND = 3'd6,
        RS_ENA = 3'd7
    } rsel_e;

    typedef struct packed {
        logic   req;
        amode_e mode;
        logic   sel;
    } xfer_t;

    function automatic logic mode_moves(amode_e m);
        return (m == AM_INC) || (m == AM_IDX);
    endfunction

    function automatic logic [2:0] ptr_code(int bank, int slot);
        return 3'(2 * bank + slot);
    endfunction

    function automatic logic [2:0] idx_code(int bank);
        return 3'(4 + bank);
    endfunction
endpackage

// File: rtl/mag_step.sv
`timescale 1ns/1ps
module mag_step
    import mag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] idx,
    input  amode_e        mode,
    input  logic          mod_en,
    input  logic [AW-1:0] ms,
    input  logic [AW-1:0] me,
    output logic [AW-1:0] nxt,
    output logic          hit
);
    localparam logic [AW-1:0] STEP = AW'(2);

    logic [AW-1:0] inc;

    always_comb begin
        inc = (mode == AM_IDX) ? idx : STEP;
        hit = mod_en && mode_moves(mode) && (cur[AW-1:1] == me[AW-1:1]);
        if (!mode_moves(mode))
            nxt = cur;
        else if (hit)
            nxt = {ms[AW-1:1], cur[0]};
        else
            nxt = cur + inc;
    end
endmodule

// File: rtl/mag_cfg.sv
`timescale 1ns/1ps
module mag_cfg
    import mag_pkg::*;
#(
    parameter int AW = 16,
    parameter int NB = NBANK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_bnd,
    input  logic          wr_ena,
    input  logic [2*AW-1:0] data,
    output logic [AW-1:0] ms,
    output logic [AW-1:0] me,
    output logic [NB-1:0] ena
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ms  <= '0;
            me  <= '0;
            ena <= '0;
        end else begin
            if (wr_bnd) begin
                me <= data[2*AW-1:AW];
                ms <= data[AW-1:0];
            end
            if (wr_ena)
                ena <= data[NB-1:0];
        end
    end

    // R1: bounds and enables come out of reset cleared
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ms == '0 && me == '0 && ena == '0));
endmodule

// File: rtl/mag_bank.sv
`timescale 1ns/1ps
module mag_bank
    import mag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_t         xf,
    input  logic          wr_p0,
    input  logic          wr_p1,
    input  logic          wr_idx,
    input  logic [AW-1:0] wr_val,
    input  logic          mod_en,
    input  logic [AW-1:0] ms,
    input  logic [AW-1:0] me,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] p0, p1, idx;
    logic          hit;
    logic          upd;
    logic          wr_tgt;
    logic          sel_q;

    assign addr   = xf.sel ? p1 : p0;
    assign upd    = xf.req && mode_moves(xf.mode);
    assign wr_tgt = xf.sel ? wr_p1 : wr_p0;

    mag_step #(.AW(AW)) u_step (
        .cur    (addr),
        .idx    (idx),
        .mode   (xf.mode),
        .mod_en (mod_en),
        .ms     (ms),
        .me     (me),
        .nxt    (nxt),
        .hit    (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            p0    <= '0;
            p1    <= '0;
            idx   <= '0;
            sel_q <= 1'b0;
        end else begin
            if (wr_p0)
                p0 <= wr_val;
            else if (upd && !xf.sel)
                p0 <= nxt;
            if (wr_p1)
                p1 <= wr_val;
            else if (upd && xf.sel)
                p1 <= nxt;
            if (wr_idx)
                idx <= wr_val;
            sel_q <= xf.sel;
        end
    end

    // R4: the chosen pointer holds the offered next value after the edge
    assert_commit_R4: assert property (@(posedge clk) disable iff (rst)
        (upd && !wr_tgt) |=> ((sel_q ? p1 : p0) == $past(nxt)));

    // R5: a pre-update match on the end bound reloads the start bound
    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (upd && !wr_tgt && mod_en && addr[AW-1:1] == me[AW-1:1])
        |=> ((sel_q ? p1 : p0) == {$past(ms[AW-1:1]), $past(addr[0])}));

    // R6: hold modes leave both pointers untouched
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (xf.req && !mode_moves(xf.mode) && !wr_p0 && !wr_p1)
        |=> ($stable(p0) && $stable(p1)));

    // R7: with the bank disabled a +2 step never wraps
    assert_plain_step_R7: assert property (@(posedge clk) disable iff (rst)
        (upd && !mod_en && xf.mode == AM_INC) |-> (nxt == addr + AW'(2)));
endmodule

// File: rtl/modaddr_gen.sv
`timescale 1ns/1ps
module modaddr_gen
    import mag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            x_req,
    input  logic [1:0]      x_mode,
    input  logic            x_sel,
    input  logic            y_req,
    input  logic [1:0]      y_mode,
    input  logic            y_sel,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [2*AW-1:0] wr_data,
    output logic [AW-1:0]   x_addr,
    output logic [AW-1:0]   y_addr,
    output logic [AW-1:0]   x_next,
    output logic [AW-1:0]   y_next
);
    localparam int DW = 2 * AW;

    logic [AW-1:0] ms, me;
    logic [NBANK-1:0] ena;
    xfer_t         xf     [NBANK];
    logic [AW-1:0] addr_a [NBANK];
    logic [AW-1:0] next_a [NBANK];

    assign xf[0] = '{req: x_req, mode: amode_e'(x_mode), sel: x_sel};
    assign xf[1] = '{req: y_req, mode: amode_e'(y_mode), sel: y_sel};

    mag_cfg #(.AW(AW), .NB(NBANK)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_bnd (wr_en && wr_sel == RS_BND),
        .wr_ena (wr_en && wr_sel == RS_ENA),
        .data   (wr_data[DW-1:0]),
        .ms     (ms),
        .me     (me),
        .ena    (ena)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        mag_bank #(.AW(AW)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .xf     (xf[b]),
            .wr_p0  (wr_en && wr_sel == ptr_code(b, 0)),
            .wr_p1  (wr_en && wr_sel == ptr_code(b, 1)),
            .wr_idx (wr_en && wr_sel == idx_code(b)),
            .wr_val (wr_data[AW-1:0]),
            .mod_en (ena[b]),
            .ms     (ms),
            .me     (me),
            .addr   (addr_a[b]),
            .nxt    (next_a[b])
        );
    end

    assign x_addr = addr_a[0];
    assign y_addr = addr_a[1];
    assign x_next = next_a[0];
    assign y_next = next_a[1];
endmodule

// File: tb/modaddr_gen_tb_top.sv
`timescale 1ns/1ps
module modaddr_gen_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        x_req = 0, y_req = 0, x_sel = 0, y_sel = 0, wr_en = 0;
    logic [1:0]  x_mode = 0, y_mode = 0;
    logic [2:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic [15:0] x_addr, y_addr, x_next, y_next;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int          port;   // 0 x_addr, 1 y_addr, 2 x_next, 3 y_next
        logic [15:0] exp;
        int          req;
    } item_t;

    item_t q[$];
    event  smp;

    always #5 clk = ~clk;

    modaddr_gen dut_i (
        .clk(clk), .rst(rst),
        .x_req(x_req), .x_mode(x_mode), .x_sel(x_sel),
        .y_req(y_req), .y_mode(y_mode), .y_sel(y_sel),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .x_addr(x_addr), .y_addr(y_addr), .x_next(x_next), .y_next(y_next)
    );

    // monitor: pops queued expectations at each sample point
    initial begin
        forever begin
            @(smp);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.port)
                    0:       act = x_addr;
                    1:       act = y_addr;
                    2:       act = x_next;
                    default: act = y_next;
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL R%0d port %0d actual %h expected %h", it.req, it.port, act, it.exp);
                end
            end
        end
    end

    task automatic exp_v(int port, logic [15:0] e, int r);
        item_t it;
        it.port = port; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic sample;
        #1;
        -> smp;
        #1;
    endtask

    task automatic idle;
        x_req = 0; y_req = 0; wr_en = 0; x_mode = 0; y_mode = 0;
    endtask

    task automatic commit;
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic wr(logic [2:0] s, logic [31:0] d);
        @(negedge clk);
        idle();
        wr_en = 1; wr_sel = s; wr_data = d;
        commit();
    endtask

    task automatic look(logic xs, logic ys);
        @(negedge clk);
        idle();
        x_sel = xs; y_sel = ys;
    endtask

    task automatic go(logic xr, logic [1:0] xm, logic xs, logic yr, logic [1:0] ym, logic ys);
        @(negedge clk);
        idle();
        x_req = xr; x_mode = xm; x_sel = xs;
        y_req = yr; y_mode = ym; y_sel = ys;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung, expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state seen through addresses and next values
        look(0, 1); exp_v(0, 16'h0000, 1); exp_v(1, 16'h0000, 1); sample();
        go(0, 2'd2, 1, 0, 2'd2, 0); exp_v(2, 16'h0000, 1); exp_v(3, 16'h0000, 1); sample();

        // R2 register loads, R3 combinational pointer choice
        wr(3'd0, 32'h0000_1000); wr(3'd1, 32'hABCD_2001);
        wr(3'd2, 32'h0000_3000); wr(3'd3, 32'h0000_0000);
        wr(3'd4, 32'h0000_0010); wr(3'd5, 32'h0000_FFFE);
        wr(3'd6, 32'h1004_1000); wr(3'd7, 32'h0000_0000);
        look(0, 0); exp_v(0, 16'h1000, 2); exp_v(1, 16'h3000, 2); sample();
        x_sel = 1; y_sel = 1; exp_v(0, 16'h2001, 3); exp_v(1, 16'h0000, 3); sample();

        // R4: +2 on X pointer 0, +index on Y pointer 0 (modulo 2^16)
        go(1, 2'd1, 0, 1, 2'd2, 0); exp_v(2, 16'h1002, 4); exp_v(3, 16'h2FFE, 4); sample();
        commit();
        look(0, 0); exp_v(0, 16'h1002, 4); exp_v(1, 16'h2FFE, 4); sample();
        x_sel = 1; exp_v(0, 16'h2001, 4); sample();   // R4 other pointer untouched

        // R5: wrap on X with +2 and with +index
        wr(3'd7, 32'h1);
        go(1, 2'd1, 0, 0, 0, 0); exp_v(2, 16'h1004, 5); sample(); commit();
        go(1, 2'd1, 0, 0, 0, 0); exp_v(2, 16'h1000, 5); sample(); commit();
        look(0, 0); exp_v(0, 16'h1000, 5); sample();
        wr(3'd0, 32'h1004);
        go(1, 2'd2, 0, 0, 0, 0); exp_v(2, 16'h1000, 5); sample(); commit();
        look(0, 0); exp_v(0, 16'h1000, 5); sample();

        // R6: hold and reserved modes at the end bound
        wr(3'd0, 32'h1004);
        go(1, 2'd0, 0, 0, 0, 0); exp_v(2, 16'h1004, 6); sample(); commit();
        go(1, 2'd3, 0, 0, 0, 0); exp_v(2, 16'h1004, 6); sample(); commit();
        look(0, 0); exp_v(0, 16'h1004, 6); sample();

        // R7 and R9: X enabled wraps, Y disabled steps past, same cycle
        wr(3'd3, 32'h1004);
        go(1, 2'd1, 0, 1, 2'd1, 1); exp_v(2, 16'h1000, 7); exp_v(3, 16'h1006, 7); sample(); commit();
        look(0, 1); exp_v(0, 16'h1000, 9); exp_v(1, 16'h1006, 9); sample();

        // R9: both enabled, both wrap in parallel
        wr(3'd7, 32'h3); wr(3'd3, 32'h1004); wr(3'd0, 32'h1004);
        go(1, 2'd2, 0, 1, 2'd1, 1); exp_v(2, 16'h1000, 9); exp_v(3, 16'h1000, 9); sample(); commit();
        look(0, 1); exp_v(0, 16'h1000, 9); exp_v(1, 16'h1000, 9); sample();

        // R8: bit 0 of bounds ignored (end 0x2005, start 0x2001)
        wr(3'd6, 32'h2005_2001); wr(3'd1, 32'h2004); wr(3'd0, 32'h2005);
        go(1, 2'd1, 1, 0, 0, 0); exp_v(2, 16'h2000, 8); sample(); commit();
        go(1, 2'd1, 0, 0, 0, 0); exp_v(2, 16'h2001, 8); sample(); commit();
        look(1, 0); exp_v(0, 16'h2000, 8); sample();
        x_sel = 0; exp_v(0, 16'h2001, 8); sample();

        // R11: index step jumps over the end bound without wrapping
        wr(3'd6, 32'h1004_1000); wr(3'd0, 32'h0FF8);
        go(1, 2'd2, 0, 0, 0, 0); exp_v(2, 16'h1008, 11); sample(); commit();
        look(0, 0); exp_v(0, 16'h1008, 11); sample();

        // R10: write wins over simultaneous update of the same pointer
        go(1, 2'd1, 0, 0, 0, 0);
        wr_en = 1; wr_sel = 3'd0; wr_data = 32'h5555;
        commit();
        look(0, 0); exp_v(0, 16'h5555, 10); sample();

        // R1: a second reset clears the enables and bounds too
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        wr(3'd0, 32'h0000);
        go(1, 2'd1, 0, 0, 0, 0); exp_v(2, 16'h0002, 1); sample(); commit();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule